// File: doc/BRIEF.md
# Multiplexed-Address DRAM Cycle Decoder Model

This block is a device-side functional model of an asynchronous DRAM with a multiplexed address bus and a 4-bit data path. A fast system clock samples the four active-low strobes (row strobe, column strobe, write enable, output enable). The block finds their edges and works out, from the order of those edges and the write/output-enable levels at each edge, which kind of cycle the host is running. The kinds are standby, read, early write, delayed write, read-modify-write, page-mode read or write, row-only refresh, column-before-row refresh and hidden refresh.

Row and column addresses are captured on the strobe falling edges. A small behavioural cell array stores the data. The array keeps the full 11-bit row and column capture but indexes storage with only the low bits of each, so a bench can use a tiny array. The model drives or releases the data output and keeps an internal refresh row counter. Each refresh it performs appears as a one-clock pulse together with the row number refreshed. Cell retention and analog timing are not modelled.

Top module: `dram_cycle_model`

## Requirements
- R1: After reset, `dq_oe` and `rfsh_pulse` are 0, `cyc_type` is standby (code 0), and the first counter-driven refresh uses row 0.
- R2: A row strobe fall with the column strobe high captures `addr` as the row. A later column strobe fall with write enable high captures the column and reads the cell: `cyc_type` becomes read (code 1), and `dq_out` holds the cell data, driven (`dq_oe`=1) while output enable is low.
- R3: Write enable low at the column strobe fall writes `din` into the addressed cell, keeps `dq_oe` at 0 and sets `cyc_type` to early write (code 2).
- R4: Write enable falling after the column strobe fall, with output enable high throughout, writes the `din` value present at that write edge and sets `cyc_type` to delayed write (code 3). `dq_oe` stays 0.
- R5: In a read-modify-write, the old cell data is driven while output enable is low and released when output enable rises. The following write enable fall stores `din` and sets `cyc_type` to read-modify-write (code 4).
- R6: While the row strobe stays low, each further column strobe fall captures a new column in the same row. A read reports page read (code 5) and a write reports page write (code 6).
- R7: A row strobe low period with no column strobe fall ends, at the row strobe rise, in a refresh of the captured row: `rfsh_pulse`=1, `rfsh_row`=that row, `cyc_type` row-only refresh (code 7), `dq_oe`=0.
- R8: If the column strobe is already low when the row strobe falls, the model refreshes the row given by the internal counter, then increments the counter modulo 2^11. `cyc_type` becomes counter refresh (code 8), `dq_oe` stays 0 and no cell changes.
- R9: A counter refresh started while the column strobe is still held low after a read is a hidden refresh (code 9). The read data stays on `dq_out` with `dq_oe`=1.
- R10: The output is released when the column strobe rises or output enable is high. A column strobe rise with the row strobe high, or a row strobe rise after an access with the column strobe high, sets `cyc_type` to standby (code 0).
- R11: The storage index is {row[ROW_KEEP-1:0], col[COL_KEEP-1:0]}. Addresses that differ only in higher bits reach the same cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 11 | Multiplexed row/column address |
| din | input | 4 | Write data |
| dq_out | output | 4 | Read data |
| dq_oe | output | 1 | Data output driven when 1 |
| cyc_type | output | 4 | Current cycle classification code |
| rfsh_pulse | output | 1 | One-clock pulse per refresh performed |
| rfsh_row | output | 11 | Row refreshed by the latest pulse |

## Verification
Every pin, strobes included, passes through one sampling register. The decoded result is then registered, so each output reflects a pin change two rising edges after it. The bench changes pins on a falling edge, waits two rising edges and samples on the following falling edge, where both the two-cycle result and the single-cycle refresh pulse can be seen. All 16 cells of the small default array are swept, and every page, write and refresh flavour is run. The refresh counter is stepped through a full 2048-row wrap with the row checked at each step.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;
    localparam int ADDR_W = 11;
    localparam int DQ_W   = 4;

    typedef enum logic [3:0] {
        CYC_STANDBY  = 4'd0,
        CYC_READ     = 4'd1,
        CYC_EARLY_WR = 4'd2,
        CYC_DELAY_WR = 4'd3,
        CYC_RMW      = 4'd4,
        CYC_PAGE_RD  = 4'd5,
        CYC_PAGE_WR  = 4'd6,
        CYC_ROW_RF   = 4'd7,
        CYC_CNT_RF   = 4'd8,
        CYC_HIDDEN   = 4'd9
    } cyc_e;

    typedef struct packed {
        cyc_e              kind;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [ADDR_W-1:0] cnt;
        logic [ADDR_W-1:0] prow;
        logic [DQ_W-1:0]   dout;
        logic              valid;
        logic              rd_open;
        logic              col_seen;
        logic              wrote;
        logic              drove;
        logic              rfsh;
        logic              pulse;
        logic              dq_oe;
    } dram_st_t;
endpackage

// File: rtl/dram_strobe_edge.sv
module dram_strobe_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_n,
    output logic [N-1:0] lvl,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] s_q;
    logic [N-1:0] p_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_q[i] <= 1'b1;
                p_q[i] <= 1'b1;
            end else begin
                s_q[i] <= pin_n[i];
                p_q[i] <= s_q[i];
            end
        end
        assign lvl[i]  = s_q[i];
        assign fall[i] = p_q[i] & ~s_q[i];
        assign rise[i] = ~p_q[i] & s_q[i];
    end
endmodule

// File: rtl/dram_pin_stage.sv
module dram_pin_stage #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int AW = 4,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[idx] <= wdata;
    end
    assign rdata = cells[idx];
endmodule

// File: rtl/dram_cycle_model.sv
module dram_cycle_model
    import dram_cyc_pkg::*;
#(
    parameter int ROW_KEEP = 2,
    parameter int COL_KEEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   din,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic [3:0]        cyc_type,
    output logic              rfsh_pulse,
    output logic [ADDR_W-1:0] rfsh_row
);
    localparam int IDX_W = ROW_KEEP + COL_KEEP;
    localparam int STB_N = 4;
    localparam int PIN_W = ADDR_W + DQ_W;
    localparam int S_RAS = 0;
    localparam int S_CAS = 1;
    localparam int S_WE  = 2;
    localparam int S_OE  = 3;

    logic [STB_N-1:0]  stb_lvl, stb_fall, stb_rise;
    logic [PIN_W-1:0]  pin_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DQ_W-1:0]   din_s;
    logic [ADDR_W-1:0] col_sel;
    logic [IDX_W-1:0]  idx;
    logic [DQ_W-1:0]   rdata;
    logic              mem_we;
    dram_st_t          st_d, st_q;

    dram_strobe_edge #(.N(STB_N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n ({oe_n, we_n, cas_n, ras_n}),
        .lvl   (stb_lvl),
        .fall  (stb_fall),
        .rise  (stb_rise)
    );

    dram_pin_stage #(.W(PIN_W)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr, din}),
        .q     (pin_s)
    );

    assign addr_s  = pin_s[PIN_W-1:DQ_W];
    assign din_s   = pin_s[DQ_W-1:0];
    assign col_sel = stb_fall[S_CAS] ? addr_s : st_q.col;
    assign idx     = {st_q.row[ROW_KEEP-1:0], col_sel[COL_KEEP-1:0]};

    dram_cell_array #(.AW(IDX_W), .DW(DQ_W)) u_cells (
        .clk   (clk),
        .wr_en (mem_we),
        .idx   (idx),
        .wdata (din_s),
        .rdata (rdata)
    );

    always_comb begin
        st_d   = st_q;
        st_d.pulse = 1'b0;
        mem_we = 1'b0;

        // Row strobe falling: open a row, or refresh from the counter
        if (stb_fall[S_RAS]) begin
            if (!stb_lvl[S_CAS]) begin
                st_d.rfsh  = 1'b1;
                st_d.pulse = 1'b1;
                st_d.prow  = st_q.cnt;
                st_d.cnt   = st_q.cnt + 1'b1;
                if (st_q.rd_open) begin
                    st_d.kind = CYC_HIDDEN;
                end else begin
                    st_d.kind  = CYC_CNT_RF;
                    st_d.valid = 1'b0;
                end
            end else begin
                st_d.row      = addr_s;
                st_d.col_seen = 1'b0;
            end
        end

        // Column strobe falling inside an open row: read or early write
        if (stb_fall[S_CAS] && !stb_lvl[S_RAS] && !st_q.rfsh) begin
            st_d.col   = addr_s;
            st_d.drove = 1'b0;
            if (!stb_lvl[S_WE]) begin
                mem_we       = 1'b1;
                st_d.kind    = st_q.col_seen ? CYC_PAGE_WR : CYC_EARLY_WR;
                st_d.valid   = 1'b0;
                st_d.rd_open = 1'b0;
                st_d.wrote   = 1'b1;
            end else begin
                st_d.kind    = st_q.col_seen ? CYC_PAGE_RD : CYC_READ;
                st_d.dout    = rdata;
                st_d.valid   = 1'b1;
                st_d.rd_open = 1'b1;
                st_d.wrote   = 1'b0;
            end
            st_d.col_seen = 1'b1;
        end

        // Write enable falling after the column strobe: late write
        if (stb_fall[S_WE] && !stb_fall[S_CAS] && !stb_lvl[S_CAS] &&
            !stb_lvl[S_RAS] && !st_q.rfsh && st_q.col_seen && !st_q.wrote) begin
            mem_we       = 1'b1;
            st_d.kind    = st_q.drove ? CYC_RMW : CYC_DELAY_WR;
            st_d.valid   = 1'b0;
            st_d.rd_open = 1'b0;
            st_d.wrote   = 1'b1;
        end

        if (stb_rise[S_OE]) st_d.valid = 1'b0;

        if (stb_rise[S_CAS]) begin
            st_d.valid   = 1'b0;
            st_d.rd_open = 1'b0;
            if (stb_lvl[S_RAS]) st_d.kind = CYC_STANDBY;
        end

        if (stb_rise[S_RAS]) begin
            if (st_q.rfsh) begin
                st_d.rfsh = 1'b0;
            end else if (st_q.col_seen) begin
                if (stb_lvl[S_CAS]) st_d.kind = CYC_STANDBY;
            end else begin
                st_d.kind  = CYC_ROW_RF;
                st_d.pulse = 1'b1;
                st_d.prow  = st_q.row;
            end
            st_d.col_seen = 1'b0;
        end

        if (stb_lvl[S_RAS] && stb_lvl[S_CAS]) st_d.valid = 1'b0;

        st_d.dq_oe = st_d.valid & ~stb_lvl[S_OE];
        if (st_d.dq_oe) st_d.drove = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= CYC_STANDBY;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_out     = st_q.dout;
    assign dq_oe      = st_q.dq_oe;
    assign cyc_type   = st_q.kind;
    assign rfsh_pulse = st_q.pulse;
    assign rfsh_row   = st_q.prow;
endmodule

// File: rtl/dram_cycle_chk.sv
module dram_cycle_chk
    import dram_cyc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [3:0]        cyc_type,
    input logic              rfsh_pulse,
    input logic [ADDR_W-1:0] rfsh_row
);
    logic [1:0]        age_q;
    logic              have_prev_q;
    logic [ADDR_W-1:0] last_row_q;
    logic              cnt_kind;
    logic              wr_kind;

    assign cnt_kind = (cyc_type == CYC_CNT_RF) || (cyc_type == CYC_HIDDEN);
    assign wr_kind  = (cyc_type == CYC_EARLY_WR) || (cyc_type == CYC_DELAY_WR) ||
                      (cyc_type == CYC_RMW) || (cyc_type == CYC_PAGE_WR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q       <= '0;
            have_prev_q <= 1'b0;
            last_row_q  <= '0;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 1'b1;
            if (rfsh_pulse && cnt_kind) begin
                have_prev_q <= 1'b1;
                last_row_q  <= rfsh_row;
            end
        end
    end

    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(ras_n, 2) && $past(cas_n, 2)) |-> !dq_oe); // R10

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(oe_n, 2)) |-> !dq_oe); // R10

    AST_CAS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(cas_n, 2)) |-> !dq_oe); // R10

    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_kind |-> !dq_oe); // R3

    AST_CNT_REFRESH_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_CNT_RF) |-> !dq_oe); // R8

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_pulse && cnt_kind && have_prev_q) |-> (rfsh_row == ADDR_W'(last_row_q + 1'b1))); // R8

    AST_PULSE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_pulse |-> (cnt_kind || cyc_type == CYC_ROW_RF)); // R7
endmodule

bind dram_cycle_model dram_cycle_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .oe_n       (oe_n),
    .dq_oe      (dq_oe),
    .cyc_type   (cyc_type),
    .rfsh_pulse (rfsh_pulse),
    .rfsh_row   (rfsh_row)
);

// File: tb/tb_dram_cycle_model.sv
module tb_dram_cycle_model;
    import dram_cyc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DQ_W-1:0]   din = '0;
    logic [DQ_W-1:0]   dq_out;
    logic              dq_oe;
    logic [3:0]        cyc_type;
    logic              rfsh_pulse;
    logic [ADDR_W-1:0] rfsh_row;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [3:0]        exp_mem [16];
    logic [ADDR_W-1:0] cnt_exp = '0;

    always #10 clk = ~clk;

    dram_cycle_model dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe),
        .cyc_type(cyc_type), .rfsh_pulse(rfsh_pulse), .rfsh_row(rfsh_row)
    );

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cix(input int row, input int col);
        return ((row & 3) << 2) | (col & 3);
    endfunction

    task automatic open_row(input int row);
        addr = ADDR_W'(row); ras_n = 1'b0; tk(2);
    endtask

    task automatic close_row();
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tk(2);
        ras_n = 1'b1; tk(2);
    endtask

    task automatic early_write(input int row, input int col, input logic [3:0] d);
        open_row(row);
        addr = ADDR_W'(col); din = d; we_n = 1'b0; cas_n = 1'b0; tk(2);
        chk(cyc_type == CYC_EARLY_WR, "R3 kind", cyc_type, CYC_EARLY_WR);
        chk(dq_oe == 1'b0, "R3 hiz", dq_oe, 0);
        exp_mem[cix(row, col)] = d;
        close_row();
    endtask

    task automatic read_cell(input int row, input int col, input string req);
        open_row(row);
        addr = ADDR_W'(col); oe_n = 1'b0; cas_n = 1'b0; tk(2);
        chk(cyc_type == CYC_READ, {req, " kind"}, cyc_type, CYC_READ);
        chk(dq_oe == 1'b1, {req, " drive"}, dq_oe, 1);
        chk(dq_out == exp_mem[cix(row, col)], {req, " data"}, dq_out, exp_mem[cix(row, col)]);
        cas_n = 1'b1; oe_n = 1'b1; tk(2);
        chk(dq_oe == 1'b0, "R10 cas release", dq_oe, 0);
        ras_n = 1'b1; tk(2);
        chk(cyc_type == CYC_STANDBY, "R10 standby", cyc_type, CYC_STANDBY);
    endtask

    task automatic cnt_refresh(input string req);
        cas_n = 1'b0; tk(1);
        ras_n = 1'b0; tk(2);
        chk(cyc_type == CYC_CNT_RF, {req, " kind"}, cyc_type, CYC_CNT_RF);
        chk(rfsh_pulse == 1'b1, {req, " pulse"}, rfsh_pulse, 1);
        chk(rfsh_row == cnt_exp, {req, " row"}, rfsh_row, cnt_exp);
        chk(dq_oe == 1'b0, {req, " hiz"}, dq_oe, 0);
        cnt_exp = cnt_exp + 1'b1;
        ras_n = 1'b1; tk(1);
        cas_n = 1'b1; tk(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        tk(3);
        rst_n = 1'b1;
        tk(2);
        // R1 reset state
        chk(dq_oe == 1'b0, "R1 dq_oe", dq_oe, 0);
        chk(cyc_type == CYC_STANDBY, "R1 kind", cyc_type, CYC_STANDBY);
        chk(rfsh_pulse == 1'b0, "R1 pulse", rfsh_pulse, 0);

        // R3 fill every cell, R2 read every cell back
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                early_write(r, c, 4'((cix(r, c) * 7 + 3) & 15));
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                read_cell(r, c, "R2");

        // R6 page read across row 2
        open_row(2);
        for (int c = 0; c < 4; c++) begin
            addr = ADDR_W'(c); oe_n = 1'b0; cas_n = 1'b0; tk(2);
            chk(cyc_type == (c == 0 ? CYC_READ : CYC_PAGE_RD), "R6 page rd kind", cyc_type,
                c == 0 ? CYC_READ : CYC_PAGE_RD);
            chk(dq_out == exp_mem[cix(2, c)], "R6 page rd data", dq_out, exp_mem[cix(2, c)]);
            cas_n = 1'b1; oe_n = 1'b1; tk(2);
        end
        ras_n = 1'b1; tk(2);

        // R6 page write across row 3
        open_row(3);
        for (int c = 0; c < 4; c++) begin
            addr = ADDR_W'(c); din = 4'(c + 9); we_n = 1'b0; cas_n = 1'b0; tk(2);
            chk(cyc_type == (c == 0 ? CYC_EARLY_WR : CYC_PAGE_WR), "R6 page wr kind", cyc_type,
                c == 0 ? CYC_EARLY_WR : CYC_PAGE_WR);
            chk(dq_oe == 1'b0, "R6 page wr hiz", dq_oe, 0);
            exp_mem[cix(3, c)] = 4'(c + 9);
            cas_n = 1'b1; we_n = 1'b1; tk(2);
        end
        ras_n = 1'b1; tk(2);
        for (int c = 0; c < 4; c++) read_cell(3, c, "R6");

        // R4 delayed write
        open_row(1);
        addr = 11'd2; cas_n = 1'b0; tk(2);
        chk(dq_oe == 1'b0, "R4 oe high", dq_oe, 0);
        din = 4'hA; we_n = 1'b0; tk(2);
        chk(cyc_type == CYC_DELAY_WR, "R4 kind", cyc_type, CYC_DELAY_WR);
        chk(dq_oe == 1'b0, "R4 hiz", dq_oe, 0);
        exp_mem[cix(1, 2)] = 4'hA;
        close_row();
        read_cell(1, 2, "R4");

        // R5 read-modify-write
        open_row(0);
        addr = 11'd1; oe_n = 1'b0; cas_n = 1'b0; tk(2);
        chk(dq_oe == 1'b1, "R5 drive", dq_oe, 1);
        chk(dq_out == exp_mem[cix(0, 1)], "R5 old data", dq_out, exp_mem[cix(0, 1)]);
        oe_n = 1'b1; tk(2);
        chk(dq_oe == 1'b0, "R5 release", dq_oe, 0);
        din = 4'h5; we_n = 1'b0; tk(2);
        chk(cyc_type == CYC_RMW, "R5 kind", cyc_type, CYC_RMW);
        exp_mem[cix(0, 1)] = 4'h5;
        close_row();
        read_cell(0, 1, "R5");

        // R10 output enable held high during a read
        open_row(2);
        addr = 11'd3; cas_n = 1'b0; tk(2);
        chk(cyc_type == CYC_READ, "R10 read kind", cyc_type, CYC_READ);
        chk(dq_oe == 1'b0, "R10 oe high", dq_oe, 0);
        close_row();

        // R7 row-only refresh
        open_row(11'h2A5); tk(1);
        ras_n = 1'b1; tk(2);
        chk(cyc_type == CYC_ROW_RF, "R7 kind", cyc_type, CYC_ROW_RF);
        chk(rfsh_pulse == 1'b1, "R7 pulse", rfsh_pulse, 1);
        chk(rfsh_row == 11'h2A5, "R7 row", rfsh_row, 11'h2A5);
        chk(dq_oe == 1'b0, "R7 hiz", dq_oe, 0);

        // R8 counter refresh
        for (int k = 0; k < 3; k++) cnt_refresh("R8");
        read_cell(2, 2, "R8 cells kept");

        // R9 hidden refresh
        open_row(3);
        addr = 11'd1; oe_n = 1'b0; cas_n = 1'b0; tk(2);
        chk(cyc_type == CYC_READ, "R9 read kind", cyc_type, CYC_READ);
        ras_n = 1'b1; tk(2);
        chk(dq_oe == 1'b1, "R9 drive kept", dq_oe, 1);
        ras_n = 1'b0; tk(2);
        chk(cyc_type == CYC_HIDDEN, "R9 kind", cyc_type, CYC_HIDDEN);
        chk(rfsh_pulse == 1'b1, "R9 pulse", rfsh_pulse, 1);
        chk(rfsh_row == cnt_exp, "R9 row", rfsh_row, cnt_exp);
        chk(dq_oe == 1'b1, "R9 drive", dq_oe, 1);
        chk(dq_out == exp_mem[cix(3, 1)], "R9 data", dq_out, exp_mem[cix(3, 1)]);
        cnt_exp = cnt_exp + 1'b1;
        ras_n = 1'b1; tk(2);
        cas_n = 1'b1; oe_n = 1'b1; tk(2);
        chk(cyc_type == CYC_STANDBY, "R10 after hidden", cyc_type, CYC_STANDBY);
        chk(dq_oe == 1'b0, "R10 after hidden hiz", dq_oe, 0);

        // R8 counter wrap through all rows
        for (int k = 0; k < 2050; k++) cnt_refresh("R8 wrap");

        // R11 high address bits alias onto the small array
        early_write(11'h405, 11'h7F2, 4'hE);
        read_cell(1, 2, "R11");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule